// File: doc/BRIEF.md
# Modem Line Control and Status Registers

This block sits in a serial port and owns the two registers that deal with the modem handshake lines. Four active-low line inputs (clear-to-send, data-set-ready, ring indicator, carrier detect) are synchronised into the core clock domain. Their present asserted state is shown in the upper half of a status register. Change flags in the lower half record what has happened since software last read that register.

A control register drives the active-low request-to-send and data-terminal-ready outputs. It also holds two general-purpose output bits and a loopback enable. In loopback, the four status inputs are taken from the control bits instead of the pins, and both handshake outputs are parked inactive. A modem-status interrupt request is raised while any change flag is set and the external enable is high.

Software reaches both registers through a simple bus with a read strobe, a write strobe, an address and byte-wide data. Read data is registered and appears one cycle after the strobe.

Top module: `mdm_line_regs`

## Requirements
- R1: Status register bits 7, 6, 5 and 4 show the asserted (inverted pin) level of carrier detect, ring indicator, data-set-ready and clear-to-send. Each pin passes through two synchroniser flops before it is used.
- R2: Status bit 2 sets only when the ring-indicator pin has gone from low to high since the last status read. A high-to-low change of that pin leaves bit 2 unchanged.
- R3: The interrupt request is high exactly while the enable input is high and at least one of status bits 3..0 is set. It stays high until those bits are cleared.
- R4: Writing the control register (address 4) sets its bits 4..0 and reads them back, with bits 7..5 reading zero. Bit 1 set drives the request-to-send output low, and bit 1 clear drives it high. Bit 0 drives the data-terminal-ready output in the same way.
- R5: Reset drives both handshake outputs high, and so does control bit 4 (loopback) whenever it is set.
- R6: In loopback the status inputs come from the control bits: bit 1 to clear-to-send, bit 0 to data-set-ready, bit 2 to ring indicator, bit 3 to carrier detect. The pin levels are ignored.
- R7: Status bits 0, 1 and 3 set on any change of clear-to-send, data-set-ready and carrier detect respectively.
- R8: A read of the status register (address 6) returns its value and clears bits 3..0 on the same clock edge. A change captured on that same edge is kept for the next read.
- R9: After reset the control register reads 0x00, the status register reads 0x00 with all pins high, and the interrupt request is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_rd | input | 1 | Read strobe, one cycle per access |
| bus_wr | input | 1 | Write strobe, one cycle per access |
| bus_addr | input | 3 | Register address (4 control, 6 status) |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Registered read data, valid the cycle after bus_rd |
| msi_en | input | 1 | Modem-status interrupt enable |
| cts_n | input | 1 | Clear-to-send pin, active low |
| dsr_n | input | 1 | Data-set-ready pin, active low |
| ri_n | input | 1 | Ring-indicator pin, active low |
| dcd_n | input | 1 | Carrier-detect pin, active low |
| rts_n | output | 1 | Request-to-send pin, active low |
| dtr_n | output | 1 | Data-terminal-ready pin, active low |
| msi_irq | output | 1 | Modem-status interrupt request |

## Verification
A stale or corrupted line history shows up as a wrong change flag on the next status read. The first read after the bad cycle exposes it, and so does the interrupt line, which rises or falls with those flags the same cycle. A lost capture during a clearing read is caught by the read that follows, because the flag must still be there. A mis-stored control bit is visible on the handshake pins one cycle after the write, and in loopback on the upper status bits a few cycles later.

// File: rtl/mdm_pkg.sv
// Package: shared constants for the modem line register block.
// Assumes byte-wide register data and the line order CTS, DSR, RI, DCD
// for all four-bit line vectors (index 0 to 3).
package mdm_pkg;
    localparam int LINES     = 4;
    localparam int DATA_W    = 8;
    localparam int ADDR_W    = 3;
    localparam int CTRL_W    = 5;

    // Register offsets decoded by the neighbouring bus logic.
    localparam logic [ADDR_W-1:0] ADDR_CTRL = 3'd4;
    localparam logic [ADDR_W-1:0] ADDR_STAT = 3'd6;

    // Line vector indices.
    localparam int LN_CTS = 0;
    localparam int LN_DSR = 1;
    localparam int LN_RI  = 2;
    localparam int LN_DCD = 3;

    // Control register bit positions.
    localparam int CB_DTR  = 0;
    localparam int CB_RTS  = 1;
    localparam int CB_GP1  = 2;
    localparam int CB_GP2  = 3;
    localparam int CB_LOOP = 4;

    // Lines whose flag reacts only to a de-assertion (pin low to high).
    localparam logic [LINES-1:0] TRAIL_ONLY = 4'b0100;
endpackage

// File: rtl/mdm_sync.sv
// Module: multi-bit pin synchroniser.
// Each bit passes through STAGES flops on its own; bits are assumed
// independent (no coherence between bits). Reset loads RST_VAL, the
// idle level of the pins.
module mdm_sync #(
    parameter int          WIDTH   = 4,
    parameter int          STAGES  = 2,
    parameter logic        RST_VAL = 1'b1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);
    generate
        for (genvar b = 0; b < WIDTH; b++) begin : g_bit
            logic [STAGES-1:0] chain;
            // Shift the pin level through the synchroniser chain.
            always_ff @(posedge clk) begin
                if (!rst_n) chain <= {STAGES{RST_VAL}};
                else        chain <= {chain[STAGES-2:0], d[b]};
            end
            assign q[b] = chain[STAGES-1];
        end
    endgenerate
endmodule

// File: rtl/mdm_ctrl_reg.sv
// Module: modem control register and handshake pin drivers.
// Holds the low CTRL_W control bits. The pin outputs are registered
// from the value being written, so they change on the write edge.
// Assumes at most one write per cycle.
module mdm_ctrl_reg
    import mdm_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [CTRL_W-1:0] wdata,
    output logic [CTRL_W-1:0] ctrl_q,
    output logic              rts_n,
    output logic              dtr_n
);
    logic loop_next;
    assign loop_next = wdata[CB_LOOP];

    // Store the control bits on a write.
    always_ff @(posedge clk) begin
        if (!rst_n)     ctrl_q <= '0;
        else if (wr_en) ctrl_q <= wdata;
    end

    // Drive the handshake pins; loopback parks them inactive.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rts_n <= 1'b1;
            dtr_n <= 1'b1;
        end else if (wr_en) begin
            rts_n <= loop_next | ~wdata[CB_RTS];
            dtr_n <= loop_next | ~wdata[CB_DTR];
        end
    end
endmodule

// File: rtl/mdm_delta.sv
// Module: line change detector with clear-on-read flags.
// Compares the current asserted line levels with those of the previous
// cycle. Lines marked in TRAIL_ONLY flag only a de-assertion; all others
// flag any change. A clear and a new capture on the same edge keep the
// new capture.
module mdm_delta
    import mdm_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic [LINES-1:0] act,
    input  logic             clr,
    output logic [LINES-1:0] delta
);
    logic [LINES-1:0] prev;
    logic [LINES-1:0] hit;

    generate
        for (genvar i = 0; i < LINES; i++) begin : g_line
            if (TRAIL_ONLY[i]) begin : g_trail
                assign hit[i] = prev[i] & ~act[i];
            end else begin : g_any
                assign hit[i] = prev[i] ^ act[i];
            end
        end
    endgenerate

    // Remember last cycle's line levels.
    always_ff @(posedge clk) begin
        if (!rst_n) prev <= '0;
        else        prev <= act;
    end

    // Update the sticky flags: clear on read, new captures win.
    always_ff @(posedge clk) begin
        if (!rst_n) delta <= '0;
        else        delta <= (delta & {LINES{~clr}}) | hit;
    end

    // R8: a capture on a clearing edge is still present afterwards.
    a_r8_keep_on_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (|hit) |=> ((delta & $past(hit)) == $past(hit)));

    // R8: a clearing read leaves only the flags captured on that edge.
    a_r8_clear_on_read: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> ((delta & ~$past(hit)) == '0));

    // R2: the ring flag rises only after the ring line was de-asserted.
    a_r2_ring_trailing: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(delta[LN_RI]) |-> ($past(prev[LN_RI]) && !$past(act[LN_RI])));
endmodule

// File: rtl/mdm_line_regs.sv
// Module: modem line control/status register block (top).
// Synchronises the four active-low modem pins, selects pin or loopback
// sources, tracks change flags, serves register reads and writes and
// raises the modem-status interrupt request. Assumes single-cycle
// strobes and that the bus does not read and write in one cycle.
module mdm_line_regs
    import mdm_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_rd,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic              msi_en,
    input  logic              cts_n,
    input  logic              dsr_n,
    input  logic              ri_n,
    input  logic              dcd_n,
    output logic              rts_n,
    output logic              dtr_n,
    output logic              msi_irq
);
    logic [LINES-1:0]  pins_n;
    logic [LINES-1:0]  pins_sync_n;
    logic [LINES-1:0]  loop_src;
    logic [LINES-1:0]  act;
    logic [LINES-1:0]  delta;
    logic [CTRL_W-1:0] ctrl_q;
    logic [DATA_W-1:0] stat_val;
    logic              ctrl_wr;
    logic              stat_rd;
    logic              unused_wdata_hi;

    assign pins_n          = {dcd_n, ri_n, dsr_n, cts_n};
    assign ctrl_wr         = bus_wr && (bus_addr == ADDR_CTRL);
    assign stat_rd         = bus_rd && (bus_addr == ADDR_STAT);
    assign unused_wdata_hi = ^bus_wdata[DATA_W-1:CTRL_W];

    mdm_sync #(.WIDTH(LINES), .STAGES(2), .RST_VAL(1'b1)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (pins_n),
        .q     (pins_sync_n)
    );

    mdm_ctrl_reg u_ctrl (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_en  (ctrl_wr),
        .wdata  (bus_wdata[CTRL_W-1:0]),
        .ctrl_q (ctrl_q),
        .rts_n  (rts_n),
        .dtr_n  (dtr_n)
    );

    // Loopback sources in line order CTS, DSR, RI, DCD.
    assign loop_src[LN_CTS] = ctrl_q[CB_RTS];
    assign loop_src[LN_DSR] = ctrl_q[CB_DTR];
    assign loop_src[LN_RI]  = ctrl_q[CB_GP1];
    assign loop_src[LN_DCD] = ctrl_q[CB_GP2];

    // Choose the asserted line levels from pins or control bits.
    always_comb begin
        if (ctrl_q[CB_LOOP]) act = loop_src;
        else                 act = ~pins_sync_n;
    end

    mdm_delta u_delta (
        .clk   (clk),
        .rst_n (rst_n),
        .act   (act),
        .clr   (stat_rd),
        .delta (delta)
    );

    assign stat_val = {act, delta};
    assign msi_irq  = msi_en & (|delta);

    // Capture read data for the addressed register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bus_rdata <= '0;
        end else if (bus_rd) begin
            if (bus_addr == ADDR_STAT)
                bus_rdata <= stat_val;
            else if (bus_addr == ADDR_CTRL)
                bus_rdata <= {{(DATA_W-CTRL_W){1'b0}}, ctrl_q};
            else
                bus_rdata <= '0;
        end
    end

    // R4: a write with the request bit set and loopback clear asserts the pin.
    a_r4_rts_on_write: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_wr && bus_wdata[CB_RTS] && !bus_wdata[CB_LOOP]) |=> !rts_n);

    // R5: entering loopback parks both handshake pins inactive.
    a_r5_loop_parks_pins: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_wr && bus_wdata[CB_LOOP]) |=> (rts_n && dtr_n));

    // R3: a raised request holds until a status read or the enable drops.
    a_r3_irq_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (msi_irq && !stat_rd) |=> (msi_irq || !msi_en));
endmodule

// File: tb/mdm_line_regs_tb.sv
module mdm_line_regs_tb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       bus_rd = 1'b0;
    logic       bus_wr = 1'b0;
    logic [2:0] bus_addr = 3'd0;
    logic [7:0] bus_wdata = 8'd0;
    logic [7:0] bus_rdata;
    logic       msi_en = 1'b0;
    logic [3:0] pins = 4'b1111;   // {dcd_n, ri_n, dsr_n, cts_n}
    logic       rts_n, dtr_n, msi_irq;
    int         checks = 0;
    int         failures = 0;
    bit         done = 1'b0;
    logic [7:0] rd_val;

    always #2 clk = ~clk;   // 250 MHz

    mdm_line_regs dut_i (
        .clk(clk), .rst_n(rst_n), .bus_rd(bus_rd), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .msi_en(msi_en), .cts_n(pins[0]), .dsr_n(pins[1]), .ri_n(pins[2]),
        .dcd_n(pins[3]), .rts_n(rts_n), .dtr_n(dtr_n), .msi_irq(msi_irq)
    );

    // Status read vectors: {pins dcd_n,ri_n,dsr_n,cts_n ; expected status}.
    localparam logic [11:0] VEC [9] = '{
        {4'b1110, 8'h11},   // R1 R7: CTS asserted
        {4'b1100, 8'h32},   // R7: DSR asserted
        {4'b1000, 8'h70},   // R2: RI asserted (pin falls), no flag
        {4'b1100, 8'h34},   // R2: RI pin rises, flag
        {4'b0100, 8'hB8},   // R7: DCD asserted
        {4'b1111, 8'h0B},   // R7: all released
        {4'b1111, 8'h00},   // R8: no change, flags cleared
        {4'b1010, 8'h51},   // R1: CTS and RI asserted
        {4'b1111, 8'h05}    // R2 R7: both released
    };

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=0x%02h expected=0x%02h", req, act, exp);
        end
    endtask

    task automatic wait_cyc(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic bus_read(input logic [2:0] a, output logic [7:0] v);
        @(negedge clk);
        bus_rd = 1'b1; bus_addr = a;
        @(negedge clk);
        bus_rd = 1'b0;
        v = bus_rdata;
    endtask

    task automatic bus_write(input logic [2:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    initial begin
        wait_cyc(3);
        rst_n = 1'b1;
        wait_cyc(1);
        // R9: reset state
        check("R9 rts_n", {7'd0, rts_n}, 8'h01);
        check("R9 dtr_n", {7'd0, dtr_n}, 8'h01);
        check("R9 irq", {7'd0, msi_irq}, 8'h00);
        bus_read(3'd4, rd_val); check("R9 ctrl", rd_val, 8'h00);
        bus_read(3'd6, rd_val); check("R9 status", rd_val, 8'h00);

        // Vector walk over pin patterns
        for (int k = 0; k < 9; k++) begin
            pins = VEC[k][11:8];
            wait_cyc(4);
            bus_read(3'd6, rd_val);
            check("R1/R2/R7 vector", rd_val, VEC[k][7:0]);
        end

        // R4: control writes and readback
        bus_write(3'd4, 8'hE3);
        check("R4 rts_n low", {7'd0, rts_n}, 8'h00);
        check("R4 dtr_n low", {7'd0, dtr_n}, 8'h00);
        bus_read(3'd4, rd_val); check("R4 readback", rd_val, 8'h03);
        bus_write(3'd4, 8'h01);
        check("R4 rts_n high", {7'd0, rts_n}, 8'h01);
        check("R4 dtr_n still low", {7'd0, dtr_n}, 8'h00);
        bus_write(3'd5, 8'h02);   // other address ignored
        bus_read(3'd4, rd_val); check("R4 ignore other addr", rd_val, 8'h01);

        // R5 R6: loopback
        bus_write(3'd4, 8'h1F);
        check("R5 rts_n loop", {7'd0, rts_n}, 8'h01);
        check("R5 dtr_n loop", {7'd0, dtr_n}, 8'h01);
        pins = 4'b0000;           // must be ignored
        wait_cyc(4);
        bus_read(3'd6, rd_val); check("R6 loop all on", rd_val, 8'hFB);
        bus_write(3'd4, 8'h1B);
        wait_cyc(4);
        bus_read(3'd6, rd_val); check("R6 R2 loop ring off", rd_val, 8'hB4);
        pins = 4'b1111;
        wait_cyc(4);
        bus_read(3'd6, rd_val); check("R6 pins ignored", rd_val, 8'hB0);
        bus_write(3'd4, 8'h00);
        wait_cyc(4);
        bus_read(3'd6, rd_val); check("R6 leave loop", rd_val, 8'h0B);
        check("R5 rts_n after loop", {7'd0, rts_n}, 8'h01);

        // R3: interrupt gating and hold
        pins = 4'b1110;
        wait_cyc(4);
        check("R3 irq disabled", {7'd0, msi_irq}, 8'h00);
        msi_en = 1'b1;
        #1;
        check("R3 irq enabled", {7'd0, msi_irq}, 8'h01);
        wait_cyc(3);
        check("R3 irq held", {7'd0, msi_irq}, 8'h01);
        bus_read(3'd6, rd_val); check("R8 read with irq", rd_val, 8'h11);
        check("R3 irq cleared by read", {7'd0, msi_irq}, 8'h00);

        // R8: change captured on the clearing edge is kept
        @(negedge clk);
        pins = 4'b1111;           // sync1 next edge, sync2 after, flag third
        @(negedge clk);
        bus_read(3'd6, rd_val);   // read lands on the capture edge
        check("R8 read on capture edge", rd_val, 8'h00);
        check("R3 irq after capture", {7'd0, msi_irq}, 8'h01);
        bus_read(3'd6, rd_val); check("R8 capture kept", rd_val, 8'h01);
        check("R3 irq dropped", {7'd0, msi_irq}, 8'h00);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        for (int i = 0; i < 20000; i++) @(posedge clk);
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog actual=running expected=done");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule